// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block tracks the single reservation behind an atomic load-linked and store-conditional instruction pair on a 32-bit core. The decode stage hands it one strobe for each operation, the address register value, the R0 data value, and a strobe that marks an interrupt or exception being taken. The block answers in the same cycle:

- For a link-load it raises a word read request and returns the read data as the value for R0.
- For a conditional store it reports the reservation state as the T status bit and, only when T is 1, raises a full-word write request.

The reservation is one flag with no address compare. It is held in a two-state machine:

- **RSV_EMPTY** is the reset state and means no reservation is held.
- **RSV_HELD** means a link-load has armed the reservation.

The machine has two transitions:

- **T_ARM** goes from RSV_EMPTY to RSV_HELD on a link-load when no conditional store and no interrupt/exception occur in that cycle.
- **T_DROP** goes from RSV_HELD to RSV_EMPTY on any conditional store or any interrupt/exception.

In every other case the state holds. A link-load seen in RSV_HELD stays in RSV_HELD.

Top module: `llsc_reserve_unit`

## Requirements
- R1: After reset no reservation is held, so a conditional store before any link-load gives t_out=0 and wr_en=0.
- R2: A link-load asserts rd_en in the same cycle, with rd_addr equal to addr_reg and ld_data equal to rd_data. rd_en is 0 in cycles without a link-load.
- R3: After a link-load with no interrupt/exception, a later conditional store with no intervening clear gives t_valid=1 and t_out=1.
- R4: A conditional store that reports t_out=1 asserts wr_en for exactly that cycle. In that cycle wr_addr equals addr_reg, wr_data equals r0_data and wr_be equals 4'b1111.
- R5: wr_en is never 1 unless a conditional store is present in the same cycle and reports t_out=1. A failed store keeps wr_be at 4'b0000.
- R6: Every conditional store clears the reservation, so the next conditional store fails unless a new link-load comes in between.
- R7: An interrupt/exception clears the reservation, so a following conditional store gives t_out=0.
- R8: An interrupt/exception in the same cycle as a link-load wins, and the reservation stays cleared.
- R9: An interrupt/exception in the same cycle as a conditional store forces t_out=0 and no write.
- R10: A link-load and a conditional store in the same cycle both take effect. The read is issued, the store is judged on the reservation held before that cycle, and the reservation ends cleared.
- R11: t_valid equals sc_req, and t_out is 0 whenever t_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ll_req | input | 1 | Link-load strobe from decode |
| sc_req | input | 1 | Conditional-store strobe from decode |
| evt_clear | input | 1 | Interrupt or exception taken this cycle |
| addr_reg | input | 32 | Address register value |
| r0_data | input | 32 | R0 value to be stored |
| rd_data | input | 32 | Memory read data (same cycle) |
| rd_en | output | 1 | Memory read request |
| rd_addr | output | 32 | Memory read address |
| ld_data | output | 32 | Word loaded for R0 |
| wr_en | output | 1 | Gated memory write request |
| wr_addr | output | 32 | Memory write address |
| wr_data | output | 32 | Memory write data |
| wr_be | output | 4 | Write byte enables |
| t_valid | output | 1 | T result valid this cycle |
| t_out | output | 1 | Resulting T status bit |

## Verification
Three functions can fall in the same cycle:

- **Reservation clear meeting a link-load.** The interrupt/exception strobe is driven together with ll_req. The result is judged by the conditional store that follows, which must fail.
- **Reservation clear meeting a conditional store.** The strobe is driven together with sc_req. T must be 0 and no write may be issued in that very cycle.
- **Link-load meeting a conditional store.** Both strobes are driven in one cycle. The store must reflect the earlier flag, and the next store must fail.

Directed cases provoke each pairing once. A long random phase then raises all three strobes independently and compares every output against a behavioural flag model on each clock.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
    typedef enum logic {
        RSV_EMPTY = 1'b0,
        RSV_HELD  = 1'b1
    } rsv_state_e;
endpackage

// File: rtl/llsc_rsv_fsm.sv
module llsc_rsv_fsm
    import llsc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic drop,
    output logic held
);
    rsv_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RSV_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RSV_EMPTY: if (arm && !drop) state_d = RSV_HELD;   // T_ARM
            RSV_HELD:  if (drop)         state_d = RSV_EMPTY;  // T_DROP
            default:                     state_d = RSV_EMPTY;
        endcase
    end

    always_comb begin
        held = (state_q == RSV_HELD);
    end

    // R6
    drop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> !held);
    // R8
    arm_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && drop) |=> !held);
endmodule

// File: rtl/llsc_store_gate.sv
module llsc_store_gate #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              sc_req,
    input  logic              evt_clear,
    input  logic              held,
    input  logic [ADDR_W-1:0] addr_reg,
    input  logic [DATA_W-1:0] r0_data,
    output logic              t_valid,
    output logic              t_out,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [DATA_W/8-1:0] wr_be
);
    localparam int BE_W = DATA_W / 8;

    always_comb begin
        t_valid = sc_req;
        t_out   = sc_req && held && !evt_clear;
        wr_en   = t_out;
        wr_addr = addr_reg;
        wr_data = r0_data;
        wr_be   = wr_en ? {BE_W{1'b1}} : {BE_W{1'b0}};
    end

    // R5
    wr_needs_t_chk: assert final (!wr_en || (sc_req && t_out));
    // R11
    t_quiet_chk: assert final (sc_req || !t_out);
endmodule

// File: rtl/llsc_reserve_unit.sv
module llsc_reserve_unit #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ll_req,
    input  logic                sc_req,
    input  logic                evt_clear,
    input  logic [ADDR_W-1:0]   addr_reg,
    input  logic [DATA_W-1:0]   r0_data,
    input  logic [DATA_W-1:0]   rd_data,
    output logic                rd_en,
    output logic [ADDR_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]   ld_data,
    output logic                wr_en,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [DATA_W-1:0]   wr_data,
    output logic [DATA_W/8-1:0] wr_be,
    output logic                t_valid,
    output logic                t_out
);
    logic held;

    llsc_rsv_fsm fsm_i (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (ll_req),
        .drop  (sc_req | evt_clear),
        .held  (held)
    );

    llsc_store_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) gate_i (
        .sc_req    (sc_req),
        .evt_clear (evt_clear),
        .held      (held),
        .addr_reg  (addr_reg),
        .r0_data   (r0_data),
        .t_valid   (t_valid),
        .t_out     (t_out),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_be     (wr_be)
    );

    always_comb begin
        rd_en   = ll_req;
        rd_addr = addr_reg;
        ld_data = rd_data;
    end

    // R3
    armed_store_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ll_req && !sc_req && !evt_clear) |=> (!(sc_req && !evt_clear) || t_out));
    // R6
    second_store_fails_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sc_req |=> !t_out);
    // R7
    evt_kills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_clear |=> !t_out);
    // R4
    wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);
endmodule

// File: tb/llsc_reserve_unit_tb.sv
module llsc_reserve_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ll_req = 1'b0, sc_req = 1'b0, evt_clear = 1'b0;
    logic [31:0] addr_reg = '0, r0_data = '0, rd_data = '0;
    logic        rd_en, wr_en, t_valid, t_out;
    logic [31:0] rd_addr, ld_data, wr_addr, wr_data;
    logic [3:0]  wr_be;

    int n_chk = 0;
    int n_fail = 0;
    bit model_flag = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    llsc_reserve_unit dut_i (
        .clk(clk), .rst_n(rst_n), .ll_req(ll_req), .sc_req(sc_req),
        .evt_clear(evt_clear), .addr_reg(addr_reg), .r0_data(r0_data),
        .rd_data(rd_data), .rd_en(rd_en), .rd_addr(rd_addr), .ld_data(ld_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
        .t_valid(t_valid), .t_out(t_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: drive after negedge, compare mid-low phase, update model at posedge.
    task automatic step(input bit ll, input bit sc, input bit ev, input string tag);
        bit exp_t;
        @(negedge clk);
        ll_req = ll; sc_req = sc; evt_clear = ev;
        addr_reg = $urandom; r0_data = $urandom; rd_data = $urandom;
        #5;
        exp_t = sc && model_flag && !ev;
        chk({tag, " R11 t_valid"}, {31'd0, t_valid}, {31'd0, sc});
        chk({tag, " t_out"}, {31'd0, t_out}, {31'd0, exp_t});
        chk({tag, " R5 wr_en"}, {31'd0, wr_en}, {31'd0, exp_t});
        chk({tag, " R2 rd_en"}, {31'd0, rd_en}, {31'd0, ll});
        if (ll) begin
            chk({tag, " R2 rd_addr"}, rd_addr, addr_reg);
            chk({tag, " R2 ld_data"}, ld_data, rd_data);
        end
        chk({tag, " R4 wr_be"}, {28'd0, wr_be}, exp_t ? 32'hF : 32'h0);
        if (exp_t) begin
            chk({tag, " R4 wr_addr"}, wr_addr, addr_reg);
            chk({tag, " R4 wr_data"}, wr_data, r0_data);
        end
        @(posedge clk);
        if (ev || sc) model_flag = 1'b0;
        else if (ll)  model_flag = 1'b1;
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        step(0, 1, 0, "R1 store after reset");
        step(1, 0, 0, "R2 link-load");
        step(0, 0, 0, "idle");
        step(0, 1, 0, "R3 armed store");
        step(0, 1, 0, "R6 second store");
        step(1, 0, 0, "R7 arm");
        step(0, 0, 1, "R7 event");
        step(0, 1, 0, "R7 store after event");
        step(1, 0, 1, "R8 ll with event");
        step(0, 1, 0, "R8 store after");
        step(1, 0, 0, "R9 arm");
        step(0, 1, 1, "R9 store with event");
        step(0, 1, 0, "R9 store after");
        step(1, 0, 0, "R10 arm");
        step(1, 1, 0, "R10 ll with store");
        step(0, 1, 0, "R10 store after");
        step(1, 1, 0, "R10 ll with store unarmed");
        step(1, 0, 0, "R4 arm");
        step(1, 0, 0, "R4 rearm");
        step(0, 1, 0, "R4 store");
        for (int i = 0; i < 2000; i++)
            step(($urandom % 3) == 0, ($urandom % 3) == 0, ($urandom % 7) == 0, "rand");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule